// File: doc/BRIEF.md
# Z80 Lower-Window Bank Remapper

This block sits between an 8-bit CPU bus with a 16-bit address and a 512 KB external SRAM. It turns every CPU address into a 19-bit physical address. The top five CPU address bits are matched against a window defined by a base value and a compare mask. A memory access that falls inside the window has its upper physical bits taken from a page register. Any other access lands in the first 64 KB of the SRAM.

Three registers are written through the CPU's I/O space, one for each window setting: base, mask and page. A fourth port works as a swap trigger. A single ordinary I/O write to port 0x38 moves the lower 8 KB onto a physical page away from page zero. Software running in RAM can then overwrite the low memory while the boot image in page zero is left intact. Each I/O cycle the block owns holds a wait request until the block handles it, and then releases it.

Top module: `zbr_remap`

## Requirements
- R1: After a synchronous active-high reset, base = 0x00, mask = 0x1C and page = 0x00. At that point CPU address 0x0000 maps to physical 0x00000 with `banked` high.
- R2: `banked` is high exactly when `mem_req` is high and ((A[15:11] XOR base[4:0]) AND mask[4:0]) == 0. Mask bit 4 pairs with A15 and mask bit 0 with A11. With the reset values, 0x0000–0x1FFF is banked and 0x2000 is not.
- R3: While `banked` is high, physical A18..A13 equal page[5:0] and physical A12..A0 equal CPU A12..A0.
- R4: While `banked` is low, physical A18..A16 are 0 and physical A15..A0 equal the CPU address.
- R5: An I/O write with `io_m1` low to port 0x38 (the port is CPU A7..A0) loads page with 0x20. CPU 0x0000 then maps to physical 0x40000, and 0x2000 still maps to 0x02000.
- R6: An I/O read of port 0x38 leaves page unchanged. So does any port-0x38 cycle with `io_m1` high (interrupt acknowledge).
- R7: I/O writes to port 0x30 load base from data[4:0], to port 0x31 load mask from data[4:0], and to port 0x32 load page from data[5:0]. The new value takes effect for memory accesses after the clock edge that handles the write.
- R8: A read or write with `io_m1` low to one of ports 0x30, 0x31, 0x32 or 0x38 raises `io_wait` in the same cycle. `io_wait` drops after the first rising edge and stays low until `io_req` falls. I/O cycles to other ports raise no wait and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Memory access in progress |
| io_req | input | 1 | I/O access in progress |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_m1 | input | 1 | Opcode-fetch / interrupt-acknowledge marker |
| cpu_addr | input | 16 | CPU address; A7..A0 is the I/O port |
| cpu_data | input | 8 | CPU write data |
| io_wait | output | 1 | Wait request for an owned I/O cycle |
| banked | output | 1 | Access falls inside the window |
| phys_addr | output | 19 | SRAM address A18..A0 |

## Verification
A corrupted page, base or mask register shows up at once on `phys_addr` or `banked`, at the first memory access after the faulty edge. The address path is combinational, so no extra latency hides the fault. A swap that fires on a read or on an interrupt acknowledge shows up as 0x0000 mapping to 0x40000 when it should still map to 0x00000. A stuck handshake flag shows up within one cycle as `io_wait` failing to rise or failing to drop. The bench probes both edges of each window configuration and the first address outside it, so a wrong compare bit can be seen.

// File: rtl/zbr_pkg.sv
package zbr_pkg;

    localparam int CPU_AW    = 16;
    localparam int PHYS_AW   = 19;
    localparam int DATA_W    = 8;
    localparam int PORT_W    = 8;
    localparam int CMP_W     = 5;
    localparam int PAGE_W    = 6;
    localparam int LOW_W     = PHYS_AW - PAGE_W;
    localparam int NUM_PORTS = 4;

    localparam logic [PORT_W-1:0] PORT_BASE = 8'h30;
    localparam logic [PORT_W-1:0] PORT_MASK = 8'h31;
    localparam logic [PORT_W-1:0] PORT_PAGE = 8'h32;
    localparam logic [PORT_W-1:0] PORT_SWAP = 8'h38;

    localparam logic [CMP_W-1:0]  BASE_RST  = 5'h00;
    localparam logic [CMP_W-1:0]  MASK_RST  = 5'h1C;
    localparam logic [PAGE_W-1:0] PAGE_RST  = 6'h00;
    localparam logic [PAGE_W-1:0] PAGE_SWAP = 6'h20;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_SWAP = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic [CMP_W-1:0]  base;
        logic [CMP_W-1:0]  mask;
        logic [PAGE_W-1:0] page;
    } win_cfg_t;

    function automatic logic [PORT_W-1:0] port_of(input int idx);
        case (idx)
            0:       return PORT_BASE;
            1:       return PORT_MASK;
            2:       return PORT_PAGE;
            default: return PORT_SWAP;
        endcase
    endfunction

    function automatic logic in_window(input logic [CMP_W-1:0] field,
                                       input logic [CMP_W-1:0] base,
                                       input logic [CMP_W-1:0] mask);
        return ((field ^ base) & mask) == '0;
    endfunction

endpackage

// File: rtl/zbr_io_decode.sv
module zbr_io_decode
    import zbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              io_req,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              io_m1,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_data,
    output logic              io_wait,
    output reg_wr_t           wr_cmd
);

    logic [NUM_PORTS-1:0] hit_vec;
    logic                 cycle_ok;
    logic                 done_q;
    reg_sel_e             sel;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        assign hit_vec[i] = (io_port == port_of(i));
    end

    assign cycle_ok = io_req & ~io_m1 & (io_rd | io_wr) & (|hit_vec);
    assign io_wait  = cycle_ok & ~done_q;

    always_comb begin
        sel = SEL_BASE;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (hit_vec[i]) sel = reg_sel_e'(2'(i));
        end
    end

    always_comb begin
        wr_cmd.valid = io_wait & io_wr;
        wr_cmd.sel   = sel;
        wr_cmd.data  = io_data;
    end

    always_ff @(posedge clk) begin
        if (rst)          done_q <= 1'b0;
        else if (!io_req) done_q <= 1'b0;
        else if (io_wait) done_q <= 1'b1;
    end

    // R8: an owned cycle is acknowledged after one edge
    assert_wait_release_R8: assert property (@(posedge clk) disable iff (rst)
        io_wait |=> !io_wait);

endmodule

// File: rtl/zbr_cfg_regs.sv
module zbr_cfg_regs
    import zbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr_cmd,
    output win_cfg_t cfg
);

    win_cfg_t cfg_q;
    logic     unused_hi;

    assign unused_hi = ^wr_cmd.data[DATA_W-1:PAGE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.base <= BASE_RST;
            cfg_q.mask <= MASK_RST;
            cfg_q.page <= PAGE_RST;
        end else if (wr_cmd.valid) begin
            case (wr_cmd.sel)
                SEL_BASE: cfg_q.base <= wr_cmd.data[CMP_W-1:0];
                SEL_MASK: cfg_q.mask <= wr_cmd.data[CMP_W-1:0];
                SEL_PAGE: cfg_q.page <= wr_cmd.data[PAGE_W-1:0];
                SEL_SWAP: cfg_q.page <= PAGE_SWAP;
                default:  cfg_q      <= cfg_q;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R1: reset values
    assert_reset_vals_R1: assert property (@(posedge clk)
        rst |=> (cfg_q.base == BASE_RST && cfg_q.mask == MASK_RST && cfg_q.page == PAGE_RST));

    // R5: swap port loads the fixed page
    assert_swap_page_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd.valid && wr_cmd.sel == SEL_SWAP) |=> cfg_q.page == PAGE_SWAP);

    // R6: page changes only on a page or swap write
    assert_page_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_cmd.valid && (wr_cmd.sel == SEL_SWAP || wr_cmd.sel == SEL_PAGE))
        |=> $stable(cfg_q.page));

endmodule

// File: rtl/zbr_addr_map.sv
module zbr_addr_map
    import zbr_pkg::*;
(
    input  logic               mem_req,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  win_cfg_t           cfg,
    output logic               banked,
    output logic [PHYS_AW-1:0] phys_addr
);

    assign banked = mem_req & in_window(cpu_addr[CPU_AW-1 -: CMP_W], cfg.base, cfg.mask);

    for (genvar b = 0; b < PHYS_AW; b++) begin : g_bit
        if (b < LOW_W) begin : g_low
            assign phys_addr[b] = cpu_addr[b];
        end else if (b < CPU_AW) begin : g_mid
            assign phys_addr[b] = banked ? cfg.page[b-LOW_W] : cpu_addr[b];
        end else begin : g_top
            assign phys_addr[b] = banked & cfg.page[b-LOW_W];
        end
    end

endmodule

// File: rtl/zbr_remap.sv
module zbr_remap
    import zbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_req,
    input  logic               io_req,
    input  logic               io_rd,
    input  logic               io_wr,
    input  logic               io_m1,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_data,
    output logic               io_wait,
    output logic               banked,
    output logic [PHYS_AW-1:0] phys_addr
);

    reg_wr_t  wr_cmd;
    win_cfg_t cfg;

    zbr_io_decode i_decode (
        .clk     (clk),
        .rst     (rst),
        .io_req  (io_req),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .io_m1   (io_m1),
        .io_port (cpu_addr[PORT_W-1:0]),
        .io_data (cpu_data),
        .io_wait (io_wait),
        .wr_cmd  (wr_cmd)
    );

    zbr_cfg_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_cmd (wr_cmd),
        .cfg    (cfg)
    );

    zbr_addr_map i_map (
        .mem_req   (mem_req),
        .cpu_addr  (cpu_addr),
        .cfg       (cfg),
        .banked    (banked),
        .phys_addr (phys_addr)
    );

    // R2: no window hit without a memory access
    assert_idle_unbanked_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> !banked);

    // R3: offset inside the window passes through
    assert_low_pass_R3: assert property (@(posedge clk) disable iff (rst)
        banked |-> phys_addr[LOW_W-1:0] == cpu_addr[LOW_W-1:0]);

    // R4: outside the window the extra SRAM bits stay clear
    assert_upper_clear_R4: assert property (@(posedge clk) disable iff (rst)
        !banked |-> (phys_addr[PHYS_AW-1:CPU_AW] == '0 && phys_addr[CPU_AW-1:0] == cpu_addr));

endmodule

// File: tb/test_zbr_remap.sv
module test_zbr_remap;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req = 1'b0;
    logic        io_req = 1'b0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_m1 = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        io_wait;
    logic        banked;
    logic [18:0] phys_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [18:0] exp_phys;
        logic        exp_banked;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    zbr_remap i_zbr_remap (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .io_req    (io_req),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_m1     (io_m1),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .io_wait   (io_wait),
        .banked    (banked),
        .phys_addr (phys_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // driver: present a memory access and queue its expected mapping
    task automatic probe(input logic [15:0] a, input logic req,
                         input logic [18:0] ephys, input logic eb, input string tag);
        sb_item_t it;
        @(negedge clk);
        mem_req  = req;
        cpu_addr = a;
        it.exp_phys   = ephys;
        it.exp_banked = eb;
        it.tag        = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        @(negedge clk);
        mem_req = 1'b0;
    endtask

    // monitor: compare outputs against the queued expectation
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() != 0);
            #1;
            it = sb_q[0];
            chk(banked == it.exp_banked, {it.tag, " banked"}, 32'(banked), 32'(it.exp_banked));
            chk(phys_addr == it.exp_phys, {it.tag, " phys"}, 32'(phys_addr), 32'(it.exp_phys));
            void'(sb_q.pop_front());
        end
    end

    task automatic io_cycle(input logic [7:0] port, input logic [7:0] data,
                            input logic wr, input logic m1, input logic exp_wait, input string tag);
        @(negedge clk);
        cpu_addr = {8'h00, port};
        cpu_data = data;
        io_wr    = wr;
        io_rd    = ~wr;
        io_m1    = m1;
        io_req   = 1'b1;
        #1;
        chk(io_wait == exp_wait, {tag, " wait raised"}, 32'(io_wait), 32'(exp_wait));
        @(posedge clk);
        #1;
        chk(io_wait == 1'b0, {tag, " wait released"}, 32'(io_wait), 32'h0);
        @(negedge clk);
        io_req = 1'b0;
        io_wr  = 1'b0;
        io_rd  = 1'b0;
        io_m1  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        do_reset();
        // reset state and default 8 KB window
        probe(16'h0000, 1'b1, 19'h00000, 1'b1, "R1 reset map");
        probe(16'h1FFF, 1'b1, 19'h01FFF, 1'b1, "R2 R3 window top");
        probe(16'h2000, 1'b1, 19'h02000, 1'b0, "R2 R4 first outside");
        probe(16'hFFFF, 1'b1, 19'h0FFFF, 1'b0, "R4 top of space");
        probe(16'h0000, 1'b0, 19'h00000, 1'b0, "R2 no mem_req");

        // accesses that must not swap
        io_cycle(8'h38, 8'h00, 1'b0, 1'b0, 1'b1, "R8 R6 read swap port");
        probe(16'h0000, 1'b1, 19'h00000, 1'b1, "R6 after read");
        io_cycle(8'h38, 8'h00, 1'b1, 1'b1, 1'b0, "R8 R6 m1 cycle");
        probe(16'h0000, 1'b1, 19'h00000, 1'b1, "R6 after m1");
        io_cycle(8'h39, 8'h3F, 1'b1, 1'b0, 1'b0, "R8 foreign port");
        probe(16'h0000, 1'b1, 19'h00000, 1'b1, "R8 foreign no effect");

        // swap
        io_cycle(8'h38, 8'h00, 1'b1, 1'b0, 1'b1, "R5 R8 swap write");
        probe(16'h0000, 1'b1, 19'h40000, 1'b1, "R5 swapped base");
        probe(16'h1234, 1'b1, 19'h41234, 1'b1, "R5 R3 swapped offset");
        probe(16'h2000, 1'b1, 19'h02000, 1'b0, "R5 R4 above window");

        // register writes
        io_cycle(8'h32, 8'h3F, 1'b1, 1'b0, 1'b1, "R7 page write");
        probe(16'h0000, 1'b1, 19'h7E000, 1'b1, "R7 R3 page 0x3F");
        io_cycle(8'h32, 8'hFF, 1'b1, 1'b0, 1'b1, "R7 page wide data");
        probe(16'h1FFF, 1'b1, 19'h7FFFF, 1'b1, "R7 page bits 5:0 only");
        io_cycle(8'h31, 8'h18, 1'b1, 1'b0, 1'b1, "R7 mask write");
        probe(16'h2000, 1'b1, 19'h7E000, 1'b1, "R7 R2 16K window");
        probe(16'h4000, 1'b1, 19'h04000, 1'b0, "R7 R2 past 16K");
        io_cycle(8'h30, 8'h08, 1'b1, 1'b0, 1'b1, "R7 base write");
        probe(16'h0000, 1'b1, 19'h00000, 1'b0, "R7 R2 moved window");
        probe(16'h5ABC, 1'b1, 19'h7FABC, 1'b1, "R7 R3 moved window hit");
        io_cycle(8'h31, 8'h00, 1'b1, 1'b0, 1'b1, "R7 mask clear");
        probe(16'hC123, 1'b1, 19'h7E123, 1'b1, "R7 R2 whole space");

        // second reset restores defaults
        do_reset();
        probe(16'h0000, 1'b1, 19'h00000, 1'b1, "R1 reset after use");
        probe(16'h2000, 1'b1, 19'h02000, 1'b0, "R1 mask restored");

        summary();
    end

endmodule